// File: doc/BRIEF.md
# Mailbox Doorbell Register Bank

This block is the register bank that a host and a service controller share for passing messages. It holds a set of 64-bit mailbox words and two doorbell registers: one that the host rings to tell the controller a command is waiting, and one that the controller (and internal event sources) ring to notify the host. All access goes through a word-addressed 64-bit bus, where the word offset is the byte address shifted right by three. Every access moves a full 8-byte word.

Each doorbell can be changed in three ways, each at its own offset. A load replaces the value, an AND clears bits, and an OR sets bits. Bits are numbered MSB-0, so doorbell bit n is vector bit [63-n]. The controller doorbell keeps only its message-waiting bit, and that bit never stays set. When an update leaves it set, the block sends a one-cycle `msg_pend` pulse toward the command processor and stores the bit as 0. The host doorbell keeps a fixed set of legal bits. Two internal set-request inputs can also set bits in it, and the host interrupt is high whenever any of its bits is set.

The bus has no back-pressure. A read or write strobe is taken in the cycle it is high. A read returns one cycle later with `rd_valid`, and no request is ever stalled or dropped.

Top module: `mdb_bank`

## Requirements
- R1: Mailbox words 0..7 sit at word offsets 0x00..0x07. Words 0-3 are for commands and words 4-7 for responses. Each is plain 64-bit read/write storage: a write replaces the word and leaves all other words unchanged.
- R2: A read strobe in one cycle makes `rd_valid` high in the next cycle, with `rd_data` holding the addressed value. If a write and a read hit the same offset in one cycle, the read returns the value from before the write. `rd_valid` is low in any cycle that does not follow a read strobe.
- R3: Reading an unimplemented offset returns zero. These are 0x08..0x0F and 0x16 and up. Writing one changes no mailbox word and neither doorbell.
- R4: The controller doorbell is written at offset 0x10 (load), 0x11 (AND with the current value) and 0x12 (OR with the current value). Only bit [63] (MSB-0 bit 0, message waiting) is kept, and all other bits are discarded.
- R5: When a controller doorbell update leaves bit [63] set, `msg_pend` is high for exactly the next cycle. The stored bit clears at the same edge, so reading offset 0x10 always returns 0. An update that leaves bit [63] clear produces no pulse.
- R6: The host doorbell is written at offset 0x13 (load), 0x14 (AND) and 0x15 (OR), and is read at 0x13. After every update it keeps only the bits in mask 64'hF802_0000_0000_0000. These are MSB-0 bits 0-4 (response waiting, message read, stop exit, reset, passthrough) and bit 14 (timer expiry).
- R7: `set_msg_read` sets vector bit [62] and `set_timer_exp` sets vector bit [49] of the host doorbell. When they coincide with a bus update in the same cycle, the bus update is applied first and the request bits are ORed into its result.
- R8: `host_irq` is high exactly when the stored host doorbell is nonzero.
- R9: A synchronous active-high reset clears all mailbox words and both doorbells, and drives `host_irq`, `msg_pend` and `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word offset (byte address >> 3) |
| bus_wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| set_msg_read | input | 1 | Internal request to set host doorbell bit [62] |
| set_timer_exp | input | 1 | Internal request to set host doorbell bit [49] |
| msg_pend | output | 1 | One-cycle message-pending pulse to the command processor |
| host_irq | output | 1 | Host interrupt level |

## Verification
The mailbox is filled with a distinct pattern per word and then read back. This separates a broken offset decode from storage that is merely stuck. The host doorbell is driven with all-ones loads, then partial AND and OR masks, then a load of zero. These show whether the legal-bit mask is applied after every operation kind, and whether `host_irq` follows the stored value both up and down. The controller doorbell is rung through each of its three offsets, with and without bit [63] set, to tell a real pulse from a stuck or missing one. Set requests are made in the same cycle as loads and ANDs of zero, which exposes any reversal of the order in which the two are applied.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int DW = 64;

  // doorbell word offsets; the host and controller sides keep a fixed layout
  localparam logic [7:0] OFF_CDB_LD  = 8'h10;
  localparam logic [7:0] OFF_CDB_AND = 8'h11;
  localparam logic [7:0] OFF_CDB_OR  = 8'h12;
  localparam logic [7:0] OFF_HDB_LD  = 8'h13;
  localparam logic [7:0] OFF_HDB_AND = 8'h14;
  localparam logic [7:0] OFF_HDB_OR  = 8'h15;

  // MSB-0 numbering: bit n lives at vector index DW-1-n
  localparam logic [DW-1:0] CDB_KEEP   = 64'h8000_0000_0000_0000;
  localparam logic [DW-1:0] HDB_KEEP   = 64'hF802_0000_0000_0000;
  localparam int            HDB_MSGRD  = DW - 1 - 1;
  localparam int            HDB_TIMER  = DW - 1 - 14;

  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_LOAD = 2'd1,
    DB_AND  = 2'd2,
    DB_OR   = 2'd3
  } db_op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MBOX = 2'd1,
    SRC_CDB  = 2'd2,
    SRC_HDB  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/mdb_decode.sv
module mdb_decode
  import mdb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 8,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NWORDS-1:0] mb_we,
  output db_op_e            cdb_op,
  output db_op_e            hdb_op,
  output rd_src_e           rd_src,
  output logic [IDX_W-1:0]  rd_idx
);
  logic in_mbox;

  always_comb begin
    in_mbox = (int'(addr) < NWORDS);
    rd_idx  = addr[IDX_W-1:0];
    rd_src  = SRC_NONE;
    cdb_op  = DB_IDLE;
    hdb_op  = DB_IDLE;
    if (in_mbox) begin
      rd_src = SRC_MBOX;
    end else begin
      case (addr)
        ADDR_W'(OFF_CDB_LD):  begin rd_src = SRC_CDB; if (wr) cdb_op = DB_LOAD; end
        ADDR_W'(OFF_CDB_AND): if (wr) cdb_op = DB_AND;
        ADDR_W'(OFF_CDB_OR):  if (wr) cdb_op = DB_OR;
        ADDR_W'(OFF_HDB_LD):  begin rd_src = SRC_HDB; if (wr) hdb_op = DB_LOAD; end
        ADDR_W'(OFF_HDB_AND): if (wr) hdb_op = DB_AND;
        ADDR_W'(OFF_HDB_OR):  if (wr) hdb_op = DB_OR;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_we
    assign mb_we[i] = wr && in_mbox && (rd_idx == IDX_W'(i));
  end

  // R1: at most one mailbox word written per cycle
  we_onehot_chk: assert final ($onehot0(mb_we));
endmodule

// File: rtl/mdb_mailbox.sv
module mdb_mailbox
  import mdb_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NWORDS-1:0]         we,
  input  logic [DW-1:0]             wdata,
  output logic [NWORDS-1:0][DW-1:0] words
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)        words[i] <= '0;
      else if (we[i]) words[i] <= wdata;
    end

    // R1
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(words[i]));
  end
endmodule

// File: rtl/mdb_doorbell.sv
module mdb_doorbell
  import mdb_pkg::*;
#(
  parameter logic [DW-1:0] KEEP     = '1,
  parameter logic [DW-1:0] SELF_CLR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  db_op_e        op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] value,
  output logic          fire
);
  logic [DW-1:0] base, merged;

  always_comb begin
    case (op)
      DB_LOAD: base = wdata;
      DB_AND:  base = value & wdata;
      DB_OR:   base = value | wdata;
      default: base = value;
    endcase
    // bus result first, then internal requests on top
    merged = (base | set_bits) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      fire  <= 1'b0;
    end else begin
      value <= merged & ~SELF_CLR;
      fire  <= |(merged & SELF_CLR);
    end
  end

  // R4 R6: stored bits stay inside the legal mask
  keep_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (value & ~KEEP) == '0);

  // R5: a pulse needs an update in the previous cycle
  fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(op != DB_IDLE || set_bits != '0));
endmodule

// File: rtl/mdb_bank.sv
module mdb_bank
  import mdb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 8,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       rd_data,
  output logic              rd_valid,
  input  logic              set_msg_read,
  input  logic              set_timer_exp,
  output logic              msg_pend,
  output logic              host_irq
);
  logic [NWORDS-1:0]         mb_we;
  logic [NWORDS-1:0][DW-1:0] words;
  db_op_e                    cdb_op, hdb_op;
  rd_src_e                   rd_src;
  logic [IDX_W-1:0]          rd_idx;
  logic [DW-1:0]             cdb_val, hdb_val, hdb_set, rd_mux;
  logic                      hdb_fire_unused;

  mdb_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .mb_we(mb_we),
    .cdb_op(cdb_op), .hdb_op(hdb_op), .rd_src(rd_src), .rd_idx(rd_idx)
  );

  mdb_mailbox #(.NWORDS(NWORDS)) u_mbox (
    .clk(clk), .rst(rst), .we(mb_we), .wdata(bus_wdata), .words(words)
  );

  mdb_doorbell #(.KEEP(CDB_KEEP), .SELF_CLR(CDB_KEEP)) u_cdb (
    .clk(clk), .rst(rst), .op(cdb_op), .wdata(bus_wdata),
    .set_bits('0), .value(cdb_val), .fire(msg_pend)
  );

  always_comb begin
    hdb_set = '0;
    hdb_set[HDB_MSGRD] = set_msg_read;
    hdb_set[HDB_TIMER] = set_timer_exp;
  end

  mdb_doorbell #(.KEEP(HDB_KEEP), .SELF_CLR('0)) u_hdb (
    .clk(clk), .rst(rst), .op(hdb_op), .wdata(bus_wdata),
    .set_bits(hdb_set), .value(hdb_val), .fire(hdb_fire_unused)
  );

  assign host_irq = |hdb_val;

  always_comb begin
    case (rd_src)
      SRC_MBOX: rd_mux = words[rd_idx];
      SRC_CDB:  rd_mux = cdb_val;
      SRC_HDB:  rd_mux = hdb_val;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_mux;
    end
  end

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);

  // R5
  cdb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cdb_val == '0);

  // R7
  timer_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_timer_exp |=> hdb_val[HDB_TIMER]);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hdb_op == DB_IDLE && !set_msg_read && !set_timer_exp) |=> $stable(host_irq));
endmodule

// File: tb/sim_mdb_bank.sv
module sim_mdb_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        set_msg_read = 1'b0, set_timer_exp = 1'b0;
  logic        msg_pend, host_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [63:0] HMASK = 64'hF802_0000_0000_0000;

  always #5 clk = ~clk;

  mdb_bank u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .set_msg_read(set_msg_read),
    .set_timer_exp(set_timer_exp), .msg_pend(msg_pend), .host_irq(host_irq)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R2 rd_valid", 64'(rd_valid), 64'd1);
    d = rd_data;
    @(negedge clk);
    chk("R2 rd_valid drop", 64'(rd_valid), 64'd0);
  endtask

  function automatic logic [63:0] pat(int i);
    return 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_1234_5678);
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    chk("R9 host_irq", 64'(host_irq), 64'd0);
    chk("R9 msg_pend", 64'(msg_pend), 64'd0);
    chk("R9 rd_valid", 64'(rd_valid), 64'd0);
    rd(8'h03, v); chk("R9 mailbox", v, 64'd0);
    rd(8'h13, v); chk("R9 host doorbell", v, 64'd0);
  endtask

  task automatic t_mailbox();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) wr(8'(i), pat(i));
    for (int i = 0; i < 8; i++) begin
      rd(8'(i), v); chk($sformatf("R1 word%0d", i), v, pat(i));
    end
  endtask

  task automatic t_rd_wr_same();
    logic [63:0] v;
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h02; bus_wdata = 64'hDEAD_BEEF_0000_0002;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R2 old data on collision", rd_data, pat(2));
    rd(8'h02, v); chk("R2 new data after collision", v, 64'hDEAD_BEEF_0000_0002);
    wr(8'h02, pat(2));
  endtask

  task automatic t_unimpl();
    logic [63:0] v;
    wr(8'h13, 64'hF800_0000_0000_0000);
    wr(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'h16, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'h0F, 64'h1111_2222_3333_4444);
    rd(8'h08, v); chk("R3 read 0x08", v, 64'd0);
    rd(8'h16, v); chk("R3 read 0x16", v, 64'd0);
    rd(8'h11, v); chk("R3 read 0x11", v, 64'd0);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i), v); chk($sformatf("R3 word%0d untouched", i), v, pat(i));
    end
    rd(8'h13, v); chk("R3 host doorbell untouched", v, 64'hF800_0000_0000_0000);
    chk("R3 no pulse", 64'(msg_pend), 64'd0);
  endtask

  task automatic t_ctrl_db();
    logic [63:0] v;
    wr(8'h10, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R4 no pulse without bit0", 64'(msg_pend), 64'd0);
    rd(8'h10, v); chk("R4 other bits dropped", v, 64'd0);
    wr(8'h10, 64'h8000_0000_0000_0000);
    chk("R5 pulse on load", 64'(msg_pend), 64'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", 64'(msg_pend), 64'd0);
    rd(8'h10, v); chk("R5 bit self-cleared", v, 64'd0);
    wr(8'h11, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 AND keeps zero", 64'(msg_pend), 64'd0);
    wr(8'h12, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5 pulse on OR", 64'(msg_pend), 64'd1);
    @(negedge clk);
    chk("R5 OR pulse ends", 64'(msg_pend), 64'd0);
  endtask

  task automatic t_host_db();
    logic [63:0] v;
    wr(8'h13, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h13, v); chk("R6 load masked", v, HMASK);
    chk("R8 irq high", 64'(host_irq), 64'd1);
    wr(8'h14, 64'h3002_0000_0000_0000);
    rd(8'h13, v); chk("R6 AND", v, 64'h3002_0000_0000_0000);
    wr(8'h15, 64'h8400_0000_0000_0001);
    rd(8'h13, v); chk("R6 OR masked", v, 64'hB002_0000_0000_0000);
    wr(8'h13, 64'h07FD_FFFF_FFFF_FFFF);
    rd(8'h13, v); chk("R6 illegal only", v, 64'd0);
    chk("R8 irq low", 64'(host_irq), 64'd0);
  endtask

  task automatic t_set_req();
    logic [63:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h13; bus_wdata = 64'd0; set_timer_exp = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; set_timer_exp = 1'b0;
    rd(8'h13, v); chk("R7 timer after load", v, 64'h0002_0000_0000_0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 64'd0; set_msg_read = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; set_msg_read = 1'b0;
    rd(8'h13, v); chk("R7 msgread after AND", v, 64'h4000_0000_0000_0000);
    chk("R8 irq from request", 64'(host_irq), 64'd1);
    wr(8'h14, 64'd0);
    chk("R8 irq cleared", 64'(host_irq), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mailbox();
    t_rd_wr_same();
    t_unimpl();
    t_ctrl_db();
    t_host_db();
    t_set_req();
    wr(8'h13, HMASK);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 irq after reset", 64'(host_irq), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule